// File: doc/BRIEF.md
# Programmable Timer Time-Base

This block is the counting core of a general-purpose timer. A divider cuts the input clock down to a counter tick. The counter then runs up, down or up-and-down between zero and a programmable reload value. At the ends of each run it raises an update event. The event is seen as a one-cycle pulse and as a sticky flag that software clears with a write. The divide ratio and the reload value are written through a small register write port.

The new values are held in staging copies until an update event moves them into use. A period in progress is therefore never cut short. The divide ratio is always staged. The reload value is staged only when preload is enabled; otherwise a write reaches the counter at once. A software update strobe brings the whole unit to a known state in one cycle. The strobe also signals the event, so other logic sees the restart.

The counter and reload width is 16 bits by default. A single parameter selects a 32-bit counter and reload. The divide ratio is always 16 bits.

Top module: `tmr_timebase`

## Requirements
- R1: The counter changes once every (divide value + 1) clock cycles while counting is enabled; a divide value of 0 makes it change on every clock.
- R2: With mode code 0 (up) in control bits [3:2], the count runs 0, 1, ... up to the active reload value, and the next tick returns it to 0 and raises an update event. A period is (reload + 1) ticks.
- R3: With mode code 1 (down), the count falls to 0, and the next tick loads the reload value and raises an update event. A period is (reload + 1) ticks, and the count shows the reload value in the cycle of the pulse.
- R4: With mode code 2 (center, bottom only), the count climbs from 0 to the reload value and falls back to 0. An update event is raised only on the tick that leaves 0 upward. Events are 2*reload ticks apart.
- R5: With mode code 3 (center, both ends), events are raised on the tick that leaves the top and on the tick that leaves the bottom. Events are reload ticks apart.
- R6: With preload on (control bit 1 = 1), a write to the reload register (address 2) does not change the period in progress. The new value is used from the next update event onward.
- R7: With preload off (control bit 1 = 0), a reload write takes effect at once. If the new value is below the current up-count, the counter keeps rising, wraps through its full width to 0, and raises the event only when it next equals the new value.
- R8: A write to the divide register (address 1) is always staged: the old divide value stays in use until the next update event.
- R9: Writing 1 to bit 0 at address 4 causes the following on the next clock edge: the count goes to 0, the center direction resets to rising, both staged values are loaded, and the divider restarts. The update flag is set and the pulse is raised. This happens whether counting is enabled or not.
- R10: The update flag (output updFlag) is set by every update event. It stays set until a write of 1 to bit 0 at address 3 clears it. An event in the same cycle as the clear wins, and the flag stays set.
- R11: When the enable bit (control bit 0 at address 0) is 0, the count and the divider hold their values.
- R12: Bits of a write above bit 15 are dropped for the divide register. Bits above the counter width are dropped for the reload register.
- R13: After reset the count is 0, the flag and the pulse are low, counting is disabled, the mode is up, preload is off, the divide value is 0, and the reload value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 control, 1 divide, 2 reload, 3 flag clear, 4 software update |
| wrData | input | 32 | Write data |
| count | output | 16 or 32 | Current counter value |
| updFlag | output | 1 | Sticky update flag |
| updPulse | output | 1 | One-cycle update event pulse |

## Verification
The bench builds the block with its default 16-bit counter. This keeps the full-width wrap after a reload shrink within reach of a single directed case, which needs about 65,500 cycles. Random phases use small divide and reload values, so that every counting mode passes through many reversals, staged commits, clear/event collisions and mid-period strobes. The 32-bit variant is elaborated but not exercised.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W    = 3;
  localparam int WR_DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SWU  = 3'd4;

  typedef enum logic [1:0] {
    MODE_UP       = 2'd0,
    MODE_DOWN     = 2'd1,
    MODE_CTR_BOT  = 2'd2,
    MODE_CTR_BOTH = 2'd3
  } cnt_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;     // counting enabled
    logic swUpd;   // software update this cycle
    logic arrNow;  // reload written with preload off
  } tmr_strobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [WR_DATA_W-1:0] wrData,
  input  logic                 cntEvt,
  output tmr_strobe_t          strb,
  output cnt_mode_e            mode,
  output logic [PSC_W-1:0]     pscNext,
  output logic [CNT_W-1:0]     arrNext,
  output logic                 updFlag,
  output logic                 updPulse
);

  logic             enReg;
  logic             preReg;
  cnt_mode_e        modeReg;
  logic [PSC_W-1:0] pscStage;
  logic [CNT_W-1:0] arrStage;
  logic [PSC_W-1:0] pscWrVal;
  logic [CNT_W-1:0] arrWrVal;

  logic wrCtrl, wrPsc, wrArr, clrReq, swReq, anyEvt;

  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign wrPsc  = wrEn && (wrAddr == ADDR_PSC);
  assign wrArr  = wrEn && (wrAddr == ADDR_ARR);
  assign clrReq = wrEn && (wrAddr == ADDR_CLR) && wrData[0];
  assign swReq  = wrEn && (wrAddr == ADDR_SWU) && wrData[0];
  assign anyEvt = cntEvt || swReq;

  // field truncation to the register widths
  assign pscWrVal = wrData[PSC_W-1:0];
  generate
    if (CNT_W < WR_DATA_W) begin : g_arrNarrow
      assign arrWrVal = wrData[CNT_W-1:0];
    end else begin : g_arrFull
      assign arrWrVal = wrData;
    end
  endgenerate

  // value that an event in this cycle commits
  assign pscNext = wrPsc ? pscWrVal : pscStage;
  assign arrNext = wrArr ? arrWrVal : arrStage;

  assign strb.run    = enReg;
  assign strb.swUpd  = swReq;
  assign strb.arrNow = wrArr && !preReg;
  assign mode        = modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      preReg   <= 1'b0;
      modeReg  <= MODE_UP;
      pscStage <= '0;
      arrStage <= '1;
    end else begin
      if (wrCtrl) begin
        enReg   <= wrData[0];
        preReg  <= wrData[1];
        modeReg <= cnt_mode_e'(wrData[3:2]);
      end
      if (wrPsc) pscStage <= pscWrVal;
      if (wrArr) arrStage <= arrWrVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updFlag  <= 1'b0;
      updPulse <= 1'b0;
    end else begin
      updPulse <= anyEvt;
      if (anyEvt)      updFlag <= 1'b1;
      else if (clrReq) updFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             restart,
  input  logic             commit,
  input  logic [PSC_W-1:0] pscNext,
  output logic             tick
);

  logic [PSC_W-1:0] divCnt;
  logic [PSC_W-1:0] pscAct;

  assign tick = run && (divCnt == pscAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      pscAct <= '0;
    end else if (restart) begin
      divCnt <= '0;
      pscAct <= pscNext;
    end else begin
      if (run) divCnt <= tick ? '0 : divCnt + 1'b1;
      if (commit) pscAct <= pscNext;
    end
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  input  cnt_mode_e        mode,
  input  logic [PSC_W-1:0] pscNext,
  input  logic [CNT_W-1:0] arrNext,
  output logic [CNT_W-1:0] count,
  output logic             cntEvt
);

  logic [CNT_W-1:0] cnt, cntNxt, arrAct;
  logic             dirDown, dirNxt;
  logic             tick, isCenter;

  assign isCenter = (mode == MODE_CTR_BOT) || (mode == MODE_CTR_BOTH);

  tmr_prescale #(.PSC_W(PSC_W)) u_prescale (
    .clk     (clk),
    .rstN    (rstN),
    .run     (strb.run),
    .restart (strb.swUpd),
    .commit  (cntEvt),
    .pscNext (pscNext),
    .tick    (tick)
  );

  always_comb begin
    cntNxt = cnt;
    dirNxt = dirDown;
    cntEvt = 1'b0;
    if (tick) begin
      unique case (mode)
        MODE_UP: begin
          if (cnt == arrAct) begin
            cntNxt = '0;
            cntEvt = 1'b1;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        MODE_DOWN: begin
          if (cnt == '0) begin
            cntNxt = arrNext;
            cntEvt = 1'b1;
          end else begin
            cntNxt = cnt - 1'b1;
          end
        end
        default: begin
          if (!dirDown) begin
            if (cnt == arrAct) begin
              if (arrAct == '0) begin
                cntNxt = '0;
                cntEvt = 1'b1;
              end else begin
                cntNxt = cnt - 1'b1;
                dirNxt = 1'b1;
                cntEvt = (mode == MODE_CTR_BOTH);
              end
            end else begin
              cntNxt = cnt + 1'b1;
            end
          end else begin
            if (cnt == '0) begin
              cntNxt = (arrAct == '0) ? '0 : CNT_W'(1);
              dirNxt = 1'b0;
              cntEvt = 1'b1;
            end else begin
              cntNxt = cnt - 1'b1;
            end
          end
        end
      endcase
    end
    if (!isCenter) dirNxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dirDown <= 1'b0;
      arrAct  <= '1;
    end else if (strb.swUpd) begin
      cnt     <= '0;
      dirDown <= 1'b0;
      arrAct  <= arrNext;
    end else begin
      cnt     <= cntNxt;
      dirDown <= dirNxt;
      if (cntEvt || strb.arrNow) arrAct <= arrNext;
    end
  end

  assign count = cnt;

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter bit  WIDE_CNT = 1'b0,
  localparam int CNT_W    = WIDE_CNT ? 32 : 16,
  localparam int PSC_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [WR_DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]     count,
  output logic                 updFlag,
  output logic                 updPulse
);

  tmr_strobe_t      strb;
  cnt_mode_e        curMode;
  logic [PSC_W-1:0] pscNext;
  logic [CNT_W-1:0] arrNext;
  logic             cntEvt;

  tmr_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .cntEvt   (cntEvt),
    .strb     (strb),
    .mode     (curMode),
    .pscNext  (pscNext),
    .arrNext  (arrNext),
    .updFlag  (updFlag),
    .updPulse (updPulse)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .mode    (curMode),
    .pscNext (pscNext),
    .arrNext (arrNext),
    .count   (count),
    .cntEvt  (cntEvt)
  );

endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [31:0]      wrData,
  input logic [CNT_W-1:0] count,
  input logic             updFlag,
  input logic             updPulse,
  input logic             run,
  input logic [1:0]       mode
);

  logic swReq, clrReq, modeUp;
  assign swReq  = wrEn && (wrAddr == 3'd4) && wrData[0];
  assign clrReq = wrEn && (wrAddr == 3'd3) && wrData[0];
  assign modeUp = (mode == 2'd0);

  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !swReq) |=> $stable(count));

  // R9
  sw_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    swReq |=> (count == '0 && updFlag && updPulse));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updFlag && !clrReq) |=> updFlag);

  // R10
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |-> updFlag);

  // R2
  up_rollover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updPulse && modeUp && $past(modeUp)) |-> (count == '0));

endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .count    (count),
  .updFlag  (updFlag),
  .updPulse (updPulse),
  .run      (strb.run),
  .mode     (curMode)
);

// File: tb/tmr_timebase_tb.sv
`timescale 1ns/1ps
module tmr_timebase_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [15:0] count;
  logic        updFlag, updPulse;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;
  bit modelOn = 1'b0;

  always #5 clk = ~clk;

  tmr_timebase u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .updFlag(updFlag), .updPulse(updPulse)
  );

  // ---------------- bench reference model ----------------
  logic        mEn, mPre, mDir, mFlag, mPulse;
  logic [1:0]  mMode;
  logic [15:0] mPscPre, mArrPre, mPscAct, mArrAct, mDiv, mCnt;

  always @(posedge clk) begin : model
    logic [15:0] pscN, arrN, cN;
    logic swu, clr, tick, ev, dN;
    if (!rstN) begin
      mEn = 0; mPre = 0; mDir = 0; mFlag = 0; mPulse = 0; mMode = 0;
      mPscPre = 0; mArrPre = 16'hFFFF; mPscAct = 0; mArrAct = 16'hFFFF;
      mDiv = 0; mCnt = 0;
    end else begin
      pscN = (wrEn && wrAddr == 3'd1) ? wrData[15:0] : mPscPre;
      arrN = (wrEn && wrAddr == 3'd2) ? wrData[15:0] : mArrPre;
      swu  = wrEn && wrAddr == 3'd4 && wrData[0];
      clr  = wrEn && wrAddr == 3'd3 && wrData[0];
      tick = mEn && (mDiv == mPscAct);
      ev = 0; cN = mCnt; dN = mDir;
      if (tick) begin
        case (mMode)
          2'd0: if (mCnt == mArrAct) begin cN = 0; ev = 1; end else cN = mCnt + 16'd1;
          2'd1: if (mCnt == 0) begin cN = arrN; ev = 1; end else cN = mCnt - 16'd1;
          default: begin
            if (!mDir) begin
              if (mCnt == mArrAct) begin
                if (mArrAct == 0) begin cN = 0; ev = 1; end
                else begin cN = mCnt - 16'd1; dN = 1; ev = (mMode == 2'd3); end
              end else cN = mCnt + 16'd1;
            end else begin
              if (mCnt == 0) begin cN = (mArrAct == 0) ? 16'd0 : 16'd1; dN = 0; ev = 1; end
              else cN = mCnt - 16'd1;
            end
          end
        endcase
      end
      if (mMode < 2) dN = 0;
      if (swu) begin
        mCnt <= 0; mDir <= 0; mDiv <= 0; mPscAct <= pscN; mArrAct <= arrN;
      end else begin
        if (mEn) mDiv <= tick ? 16'd0 : mDiv + 16'd1;
        mCnt <= cN; mDir <= dN;
        if (ev) begin mPscAct <= pscN; mArrAct <= arrN; end
        else if (wrEn && wrAddr == 3'd2 && !mPre) mArrAct <= arrN;
      end
      if (wrEn && wrAddr == 3'd0) begin
        mEn <= wrData[0]; mPre <= wrData[1]; mMode <= wrData[3:2];
      end
      mPscPre <= pscN; mArrPre <= arrN;
      mPulse  <= ev || swu;
      if (ev || swu) mFlag <= 1; else if (clr) mFlag <= 0;
    end
  end

  function automatic string modeReq(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rstN && modelOn && !done) begin
      nChecks += 3;
      if (count !== mCnt) begin
        nFail++;
        $display("FAIL %s count: got %0d expected %0d", modeReq(mMode), count, mCnt);
      end
      if (updFlag !== mFlag) begin
        nFail++;
        $display("FAIL R10 flag: got %0d expected %0d", updFlag, mFlag);
      end
      if (updPulse !== mPulse) begin
        nFail++;
        $display("FAIL %s pulse: got %0d expected %0d", modeReq(mMode), updPulse, mPulse);
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] ctrlWord(input bit en, input bit pre, input logic [1:0] m);
    return {28'd0, m, pre, en};
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitPulse(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!updPulse && n < limit);
  endtask

  task automatic setup(input logic [1:0] m, input bit pre, input logic [31:0] psc, input logic [31:0] arr);
    wr(3'd0, ctrlWord(0, pre, m));
    wr(3'd1, psc);
    wr(3'd2, arr);
    wr(3'd4, 32'd1);
    wr(3'd3, 32'd1);
    wr(3'd0, ctrlWord(1, pre, m));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int n, c1, c2;
    void'($urandom(32'd20240611));
    idle(3);
    // R13 reset state
    check("R13", "count in reset", count, 0);
    check("R13", "flag in reset", updFlag, 0);
    check("R13", "pulse in reset", updPulse, 0);
    rstN = 1'b1;
    modelOn = 1'b1;
    idle(5);
    check("R13", "count idle after reset", count, 0);

    // R9 software update, R10 clear
    wr(3'd4, 32'd1);
    check("R9", "count after strobe", count, 0);
    check("R9", "flag after strobe", updFlag, 1);
    check("R9", "pulse after strobe", updPulse, 1);
    idle(3);
    check("R10", "flag sticky", updFlag, 1);
    wr(3'd3, 32'd1);
    check("R10", "flag after clear", updFlag, 0);

    // R1 R2 up mode, divide 3, reload 4
    setup(2'd0, 1'b1, 32'd2, 32'd4);
    waitPulse(100, n);
    waitPulse(100, n);
    check("R2", "up period cycles", n, 15);
    check("R2", "up count at event", count, 0);
    idle(3);
    check("R1", "count after 3 clocks", count, 1);
    idle(2);
    check("R1", "count held between ticks", count, 1);
    idle(1);
    check("R1", "count after 6 clocks", count, 2);

    // R9 divider restart mid-run, divide 4
    setup(2'd0, 1'b1, 32'd3, 32'd100);
    idle(7);
    wr(3'd4, 32'd1);
    check("R9", "count right after strobe", count, 0);
    idle(3);
    check("R9", "no early tick after strobe", count, 0);
    idle(1);
    check("R9", "first tick full period", count, 1);

    // R3 down mode
    setup(2'd1, 1'b1, 32'd0, 32'd5);
    waitPulse(100, n);
    check("R3", "down reload at event", count, 5);
    waitPulse(100, n);
    check("R3", "down period cycles", n, 6);

    // R4 center bottom only
    setup(2'd2, 1'b1, 32'd1, 32'd3);
    waitPulse(100, n);
    check("R4", "count at bottom event", count, 1);
    waitPulse(100, n);
    check("R4", "center period cycles", n, 12);

    // R5 center both ends
    setup(2'd3, 1'b1, 32'd1, 32'd3);
    waitPulse(100, n);
    c1 = count;
    waitPulse(100, n);
    c2 = count;
    check("R5", "half period cycles", n, 6);
    check("R5", "top plus bottom counts", c1 + c2, 3);

    // R6 preload on
    setup(2'd0, 1'b1, 32'd0, 32'd9);
    waitPulse(100, n);
    wr(3'd2, 32'd3);
    waitPulse(100, n);
    check("R6", "old period kept", n + 1, 10);
    waitPulse(100, n);
    check("R6", "new period after event", n, 4);

    // R8 divide always staged
    setup(2'd0, 1'b0, 32'd0, 32'd4);
    waitPulse(100, n);
    wr(3'd1, 32'd1);
    waitPulse(100, n);
    check("R8", "old divide until event", n + 1, 5);
    waitPulse(100, n);
    check("R8", "new divide after event", n, 10);

    // R12 truncation
    setup(2'd0, 1'b1, 32'h0001_0001, 32'hABCD_0004);
    waitPulse(100, n);
    waitPulse(100, n);
    check("R12", "period with truncated fields", n, 10);

    // R7 preload off, shrink below count
    setup(2'd0, 1'b0, 32'd0, 32'd9);
    waitPulse(100, n);
    idle(5);
    check("R7", "count before shrink", count, 5);
    wr(3'd2, 32'd3);
    idle(20);
    check("R7", "count runs past new reload", count, 26);
    waitPulse(70000, n);
    check("R7", "full-width wrap length", n, 65514);
    check("R7", "count after wrap event", count, 0);
    waitPulse(100, n);
    check("R7", "new reload in use", n, 4);

    // R11 disable holds
    wr(3'd0, ctrlWord(0, 1'b0, 2'd0));
    c1 = count;
    idle(10);
    check("R11", "count held when disabled", count, c1);

    // random phase checked by the model every cycle
    for (int i = 0; i < 2500; i++) begin
      logic [2:0]  a;
      logic [31:0] d;
      a = 3'($urandom % 5);
      case (a)
        3'd0: d = ctrlWord(($urandom % 4) != 0, $urandom % 2, 2'($urandom % 4));
        3'd1: d = ($urandom & 32'hFFFF_0000) | ($urandom % 4);
        3'd2: d = ($urandom & 32'hFFFF_0000) | ($urandom % 16);
        3'd3: d = $urandom % 2;
        default: d = (($urandom % 8) == 0) ? 32'd1 : 32'd0;
      endcase
      wr(a, d);
      idle($urandom % 7);
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule